// File: doc/BRIEF.md
# Single-Shot ADC Conversion Sequencer

This block is a register-mapped controller that runs one conversion at a time for a multi-channel analog-to-digital converter. Software writes a 32-bit control word to pick a channel and a reference, set a clock divider and start a conversion. The block then waits a prescaled conversion time and works out a saturated ratiometric result. It stores that result in a read-only data register and can raise a level interrupt. The analog front end is not part of the block: each channel's sample and the external reference arrive as digital value ports, and the internal reference is a parameter.

The bus is a plain single-cycle write strobe with a combinational read. The control word keeps every bit that software writes. Only the fields listed below have an effect. A conversion counts `TICKS` prescaled ticks and then hands the division to a sequential restoring divider. The result appears when the divider finishes.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After hardware reset the control word reads 0x000C0001, the data word reads 0 and `irq` is low.
- R2: The control word is at offset 0x0 and the data word at 0x4. Any other offset reads 0. Writes to 0x4 change nothing. A write whose `bus_be` is not 4'hF changes nothing.
- R3: A conversion starts only on a control write that has the enable bit (bit 17) set and takes the start/busy bit (bit 13) from 0 to 1. Bit 13 reads 1 while the conversion runs. A write with bit 17 clear, or one that leaves bit 13 at 1, starts nothing.
- R4: Bit 13 clears and the data word updates exactly 40*(D+1)+11 clock cycles after the starting write's clock edge. D is the divider field in bits 8:1. This is 20 ticks of 2*(D+1) clocks each, followed by an 11-cycle division.
- R5: The data word becomes floor(in*1024/ref), where `in` is the channel chosen by bits 27:24. `ref` is the internal reference (2,000,000) when bit 19 is 1 and `ext_ref` when bit 19 is 0. The result saturates at 1023 when in >= ref or ref = 0.
- R6: If bit 21 is set when a conversion completes, the flag (bit 18) and `irq` both go to 1. Writing the flag bit as 1 clears it and drops `irq`. Writing it as 0 leaves the flag and `irq` as they are.
- R7: A control write with bit 17 set and bit 13 clear aborts a running conversion, whether it is still counting ticks or already dividing. The data word does not change and no interrupt follows.
- R8: If bits 27:24 hold 8 or more when the tick count ends, the data word is not updated, no interrupt is raised and bit 13 stays 1.
- R9: A control write with bit 16 set restores the reset values and drops `irq`. It cancels any conversion and ignores every other bit of that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 12 | Byte offset of the access |
| bus_be | input | 4 | Byte enables; only 4'hF writes are accepted |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| chan_in | input | 256 | Eight 32-bit channel samples, channel i at bits 32*i+31:32*i |
| ext_ref | input | 32 | External reference value |
| irq | output | 1 | Level interrupt |

## Verification
Every result is due at a fixed cycle after the clock edge of the write that starts it. The bench sets the inputs on the falling edge and reads at the next falling edge. Bit 13 and the data word are read at 40*(D+1)+10 cycles, where the old values must still hold, and again at 40*(D+1)+11, where the new values must appear. This is done for dividers 0, 1, 3 and 255. Register writes and soft reset show their effect at the first falling edge after the write. Cases that must not act (blocked start, abort, invalid channel, soft reset) are read again well after the point where a conversion would have finished.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   // control word field positions
   localparam int unsigned F_START  = 13;
   localparam int unsigned F_SRST   = 16;
   localparam int unsigned F_EN     = 17;
   localparam int unsigned F_FLAG   = 18;
   localparam int unsigned F_REFSEL = 19;
   localparam int unsigned F_IE     = 21;
   localparam int unsigned SEL_LSB  = 24;
   localparam int unsigned SEL_W    = 4;
   localparam int unsigned DIV_LSB  = 1;
   localparam int unsigned DIV_W    = 8;
   localparam logic [31:0] CTRL_RST = 32'h000C_0001;
endpackage

// File: rtl/adc_tick_timer.sv
module adc_tick_timer #(
   parameter int unsigned TICKS = 20,
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             stop,
   input  logic [DIV_W-1:0] div,
   output logic             run,
   output logic             expire
);
   localparam int unsigned PW = DIV_W + 1;
   localparam int unsigned TW = (TICKS > 2) ? $clog2(TICKS) : 1;

   generate
      if (TICKS < 2) begin : g_bad_ticks
         $error("adc_tick_timer: TICKS must be at least 2");
      end
   endgenerate

   logic [PW-1:0] pc_q, lim_q;
   logic [TW-1:0] tc_q;
   logic          wrap;

   assign wrap   = (pc_q == lim_q);
   assign expire = run && wrap && (tc_q == TW'(TICKS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run   <= 1'b0;
         pc_q  <= '0;
         tc_q  <= '0;
         lim_q <= '0;
      end else if (stop) begin
         run <= 1'b0;
      end else if (start) begin
         run   <= 1'b1;
         pc_q  <= '0;
         tc_q  <= '0;
         lim_q <= {div, 1'b1};
      end else if (run) begin
         if (wrap) begin
            pc_q <= '0;
            if (tc_q == TW'(TICKS - 1)) run <= 1'b0;
            else                        tc_q <= tc_q + 1'b1;
         end else begin
            pc_q <= pc_q + 1'b1;
         end
      end
   end

   // R4
   tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (tc_q < TW'(TICKS)));
endmodule

// File: rtl/adc_ratio_div.sv
module adc_ratio_div #(
   parameter int unsigned IN_W = 32,
   parameter int unsigned Q_W  = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            cancel,
   input  logic [IN_W-1:0] num,
   input  logic [IN_W-1:0] den,
   output logic            busy,
   output logic            done,
   output logic [Q_W-1:0]  quo
);
   localparam int unsigned CW = (Q_W > 2) ? $clog2(Q_W) : 1;

   generate
      if (Q_W < 2 || Q_W > IN_W) begin : g_bad_qw
         $error("adc_ratio_div: Q_W out of range");
      end
   endgenerate

   logic [IN_W-1:0] rem_q;
   logic [IN_W:0]   rem2;
   logic            ge;
   logic [Q_W-1:0]  q_q;
   logic [CW-1:0]   cnt_q;
   logic            sat_q;

   assign rem2 = {rem_q, 1'b0};
   assign ge   = (rem2 >= {1'b0, den});
   assign quo  = sat_q ? '1 : q_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         q_q   <= '0;
         cnt_q <= '0;
         sat_q <= 1'b0;
         busy  <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (cancel) begin
            busy <= 1'b0;
         end else if (start) begin
            rem_q <= num;
            q_q   <= '0;
            cnt_q <= '0;
            sat_q <= (den == '0) || (num >= den);
            busy  <= 1'b1;
         end else if (busy) begin
            rem_q <= ge ? IN_W'(rem2 - {1'b0, den}) : rem2[IN_W-1:0];
            q_q   <= {q_q[Q_W-2:0], ge};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CW'(Q_W - 1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   // R4
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int unsigned CH_COUNT = 8,
   parameter int unsigned IN_W     = 32,
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned TICKS    = 20,
   parameter int unsigned RES_W    = 10,
   parameter int unsigned INT_REF  = 2000000
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_wr,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [3:0]               bus_be,
   input  logic [31:0]              bus_wdata,
   output logic [31:0]              bus_rdata,
   input  logic [CH_COUNT*IN_W-1:0] chan_in,
   input  logic [IN_W-1:0]          ext_ref,
   output logic                     irq
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(4);

   generate
      if (CH_COUNT < 1 || CH_COUNT > (1 << SEL_W)) begin : g_bad_ch
         $error("adc_seq_ctrl: CH_COUNT out of range");
      end
      if (RES_W > 31 || RES_W >= IN_W) begin : g_bad_res
         $error("adc_seq_ctrl: RES_W out of range");
      end
   endgenerate

   logic [31:0]      ctrl_q, ctrl_mid, ctrl_w, ctrl_n;
   logic [RES_W-1:0] data_q, data_n;
   logic             irq_n;
   logic             wr_ctrl, srst, abort, tmr_start, cancel;
   logic             tmr_run, tmr_expire, div_busy, div_done;
   logic [RES_W-1:0] div_quo;
   logic [SEL_W-1:0] sel;
   logic             sel_ok;
   logic [IN_W-1:0]  sel_val, ref_val;
   logic [IN_W-1:0]  ch [CH_COUNT];

   genvar gi;
   generate
      for (gi = 0; gi < CH_COUNT; gi++) begin : g_ch
         assign ch[gi] = chan_in[gi*IN_W +: IN_W];
      end
   endgenerate

   assign sel     = ctrl_q[SEL_LSB +: SEL_W];
   assign sel_ok  = (32'(sel) < CH_COUNT);
   assign ref_val = ctrl_q[F_REFSEL] ? IN_W'(INT_REF) : ext_ref;
   assign wr_ctrl = bus_wr && (bus_be == 4'hF) && (bus_addr == A_CTRL);

   always_comb begin
      sel_val = '0;
      for (int i = 0; i < CH_COUNT; i++)
         if (sel == SEL_W'(i)) sel_val = ch[i];
   end

   always_comb begin
      ctrl_mid  = ctrl_q;
      data_n    = data_q;
      irq_n     = irq;
      if (div_done) begin
         data_n            = div_quo;
         ctrl_mid[F_START] = 1'b0;
         if (ctrl_q[F_IE]) begin
            ctrl_mid[F_FLAG] = 1'b1;
            irq_n            = 1'b1;
         end
      end
      ctrl_n    = ctrl_mid;
      ctrl_w    = bus_wdata;
      tmr_start = 1'b0;
      abort     = 1'b0;
      srst      = 1'b0;
      if (wr_ctrl) begin
         if (bus_wdata[F_FLAG]) begin
            ctrl_w[F_FLAG] = 1'b0;
            irq_n          = 1'b0;
         end else begin
            ctrl_w[F_FLAG] = ctrl_mid[F_FLAG];
         end
         if (bus_wdata[F_SRST]) begin
            srst   = 1'b1;
            ctrl_n = CTRL_RST;
            data_n = '0;
            irq_n  = 1'b0;
         end else begin
            ctrl_n = ctrl_w;
            if (ctrl_w[F_EN]) begin
               if (ctrl_w[F_START]) tmr_start = !ctrl_mid[F_START];
               else                 abort     = 1'b1;
            end
         end
      end
   end

   assign cancel = srst || abort || tmr_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RST;
         data_q <= '0;
         irq    <= 1'b0;
      end else begin
         ctrl_q <= ctrl_n;
         data_q <= data_n;
         irq    <= irq_n;
      end
   end

   always_comb begin
      case (bus_addr)
         A_CTRL:  bus_rdata = ctrl_q;
         A_DATA:  bus_rdata = 32'(data_q);
         default: bus_rdata = '0;
      endcase
   end

   adc_tick_timer #(.TICKS(TICKS), .DIV_W(DIV_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (tmr_start),
      .stop   (srst || abort),
      .div    (ctrl_n[DIV_LSB +: DIV_W]),
      .run    (tmr_run),
      .expire (tmr_expire)
   );

   adc_ratio_div #(.IN_W(IN_W), .Q_W(RES_W)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (tmr_expire && sel_ok),
      .cancel (cancel),
      .num    (sel_val),
      .den    (ref_val),
      .busy   (div_busy),
      .done   (div_done),
      .quo    (div_quo)
   );

   // R6
   irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ctrl_q[F_FLAG]);

   // R3
   start_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmr_run) |-> (ctrl_q[F_EN] && ctrl_q[F_START]));

   // R7
   abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && bus_wdata[F_EN] && !bus_wdata[F_START] && !bus_wdata[F_SRST])
      |=> (!tmr_run && !div_busy));

   // R5
   data_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_q != $past(data_q)) |-> ($past(div_done) || $past(wr_ctrl && bus_wdata[F_SRST])));

   // R8
   bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_expire && !sel_ok && !wr_ctrl) |=> (ctrl_q[F_START] && !div_busy));
endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [3:0]  bus_be = 4'hF;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [255:0] chan_in;
   logic [31:0] ext_ref = 32'd3000000;
   logic        irq;
   logic [31:0] ch [8];
   int n_chk = 0;
   int n_err = 0;

   always #2 clk = ~clk;

   for (genvar g = 0; g < 8; g++) begin : g_pack
      assign chan_in[g*32 +: 32] = ch[g];
   end

   adc_seq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .chan_in(chan_in), .ext_ref(ext_ref), .irq(irq)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
      end
   endtask

   function automatic logic [31:0] mk(input int sel, input bit ie, input bit rs, input bit flag,
                                      input bit en, input bit srst, input bit conv, input int dv);
      return (32'(sel) << 24) | (32'(ie) << 21) | (32'(rs) << 19) | (32'(flag) << 18)
           | (32'(en) << 17) | (32'(srst) << 16) | (32'(conv) << 13) | ((32'(dv) & 32'hFF) << 1);
   endfunction

   function automatic logic [31:0] expect_res(input logic [31:0] in, input logic [31:0] rf);
      longint unsigned q;
      if (rf == 0) return 32'd1023;
      q = (longint'(in) * 1024) / longint'(rf);
      return (q > 1023) ? 32'd1023 : 32'(q);
   endfunction

   task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0; bus_be = 4'hF;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] v);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(12'h0, v); check("R1 ctrl reset", v, 32'h000C0001);
      rd(12'h4, v); check("R1 data reset", v, 0);
      check("R1 irq reset", 32'(irq), 0);
   endtask

   task automatic t_decode();
      logic [31:0] v;
      rd(12'h8, v);   check("R2 unmapped 0x8", v, 0);
      rd(12'hFFC, v); check("R2 unmapped 0xFFC", v, 0);
      wr(12'h4, 32'h0000_03FF, 4'hF);
      rd(12'h4, v);   check("R2 data write ignored", v, 0);
      wr(12'h0, 32'h0000_0000, 4'h3);
      rd(12'h0, v);   check("R2 partial write ignored", v, 32'h000C0001);
      wr(12'h0, mk(0,0,0,1,0,0,0,0), 4'hF);
      rd(12'h0, v);   check("R6 flag W1C after reset", v, 0);
   endtask

   task automatic t_convert(input int sel, input bit rs, input int dv, input bit ie);
      logic [31:0] v, old, exp;
      int lat;
      lat = 40 * (dv + 1) + 11;
      exp = expect_res(ch[sel], rs ? 32'd2000000 : ext_ref);
      rd(12'h4, old);
      wr(12'h0, mk(sel, ie, rs, 0, 1, 0, 1, dv), 4'hF);
      rd(12'h0, v); check("R3 busy after start", 32'(v[13]), 1);
      repeat (lat - 1) @(negedge clk);
      rd(12'h0, v); check("R4 busy one cycle early", 32'(v[13]), 1);
      rd(12'h4, v); check("R4 data held one cycle early", v, old);
      @(negedge clk);
      rd(12'h0, v); check("R4 busy cleared on time", 32'(v[13]), 0);
      rd(12'h4, v); check("R5 result", v, exp);
      check("R6 irq follows enable", 32'(irq), 32'(ie));
   endtask

   task automatic t_irq();
      logic [31:0] v;
      wr(12'h0, mk(0,1,0,0,1,0,0,0), 4'hF);
      rd(12'h0, v); check("R6 flag held by write 0", 32'(v[18]), 1);
      check("R6 irq held by write 0", 32'(irq), 1);
      wr(12'h0, mk(0,1,0,1,1,0,0,0), 4'hF);
      rd(12'h0, v); check("R6 flag cleared", 32'(v[18]), 0);
      check("R6 irq cleared", 32'(irq), 0);
   endtask

   task automatic t_blocked();
      logic [31:0] v, old;
      rd(12'h4, old);
      wr(12'h0, mk(2,0,1,0,0,0,1,0), 4'hF);
      repeat (80) @(negedge clk);
      rd(12'h0, v); check("R3 bit stored while disabled", 32'(v[13]), 1);
      rd(12'h4, v); check("R3 no start when disabled", v, old);
      wr(12'h0, mk(2,0,1,0,1,0,1,0), 4'hF);
      repeat (80) @(negedge clk);
      rd(12'h4, v); check("R3 no start without rising edge", v, old);
      wr(12'h0, mk(2,0,1,0,1,0,0,0), 4'hF);
   endtask

   task automatic t_abort(input int gap);
      logic [31:0] v, old;
      rd(12'h4, old);
      wr(12'h0, mk(4,1,1,0,1,0,1,0), 4'hF);
      repeat (gap) @(negedge clk);
      wr(12'h0, mk(4,1,1,0,1,0,0,0), 4'hF);
      repeat (80) @(negedge clk);
      rd(12'h4, v); check("R7 data unchanged after abort", v, old);
      rd(12'h0, v); check("R7 busy clear after abort", 32'(v[13]), 0);
      check("R7 no irq after abort", 32'(irq), 0);
   endtask

   task automatic t_invalid();
      logic [31:0] v, old;
      rd(12'h4, old);
      wr(12'h0, mk(9,1,1,0,1,0,1,0), 4'hF);
      repeat (80) @(negedge clk);
      rd(12'h0, v); check("R8 busy stays set", 32'(v[13]), 1);
      rd(12'h4, v); check("R8 data not updated", v, old);
      check("R8 no irq", 32'(irq), 0);
      wr(12'h0, mk(9,1,1,0,1,0,0,0), 4'hF);
   endtask

   task automatic t_softreset();
      logic [31:0] v;
      wr(12'h0, mk(3,1,0,0,1,1,1,5), 4'hF);
      rd(12'h0, v); check("R9 ctrl restored", v, 32'h000C0001);
      rd(12'h4, v); check("R9 data cleared", v, 0);
      check("R9 irq dropped", 32'(irq), 0);
      repeat (300) @(negedge clk);
      rd(12'h4, v); check("R9 no conversion from reset write", v, 0);
      rd(12'h0, v); check("R9 ctrl still reset", v, 32'h000C0001);
   endtask

   initial begin
      for (int i = 0; i < 8; i++) ch[i] = 32'(100000 * (i + 1));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_decode();
      ch[3] = 32'd500000;
      t_convert(3, 1, 0, 1);
      t_irq();
      ch[5] = 32'd1234567;
      t_convert(5, 0, 3, 0);
      ch[0] = 32'd2500000;
      t_convert(0, 1, 1, 0);
      ext_ref = 32'd1000000; ch[1] = 32'd999999;
      t_convert(1, 0, 0, 0);
      ext_ref = 32'd3000000; ch[2] = 32'd7;
      t_convert(2, 0, 0, 0);
      ext_ref = 32'd0;
      t_convert(6, 0, 0, 0);
      ext_ref = 32'd3000000;
      ch[7] = 32'd1999999;
      t_convert(7, 1, 255, 0);
      ch[2] = 32'd1000000;
      t_blocked();
      ch[4] = 32'd300000;
      t_abort(20);
      t_abort(44);
      t_invalid();
      t_convert(3, 1, 0, 1);
      t_softreset();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule